// File: doc/BRIEF.md
# Serial Priority-Arbitrated Frame Transmitter

This block sends one data frame or one remote-request frame on a shared single-wire bus with wired-AND levels. A node pulls the line low (dominant) to send a 0 and lets it float high (recessive) to send a 1. The bus sits recessive when idle. One bit goes out per pulse of a bit-time strobe. The frame is a reduced form with no bit stuffing. In order it carries a dominant start bit, an 11-bit identifier and a remote flag, a 6-bit control field, 0 to 8 data bytes, a 16-bit checksum, a 2-bit acknowledge field and seven recessive closing bits.

The host presents the identifier, the remote flag, a 4-bit length code and the data. It then raises a start request. While the identifier and the remote flag go out, the block compares the bus level it senses with the bit it sends. If it sends recessive and senses dominant, another node holds a higher priority. The block then drops off the bus and tries again once the bus has been recessive for the gap time. If no other node pulls the acknowledge slot dominant, the block sends the frame again. After a fixed number of such attempts it gives up and reports an error.

Top module: `busFrameTx`

## Requirements
- R1: After reset, busDrive is 1 (recessive), busy is 0, and done, doneErr, lostArb and retry are all 0.
- R2: startReq is taken only on a bitTick cycle while busy is 0. A request on any other clock is ignored. Once a request is taken, busy rises, and the start bit (0) is driven after exactly 3 consecutive ticks on which the bus is sensed recessive.
- R3: Frame bits 1 to 11 carry txId MSB first (bit 1 = txId[10]), and bit 12 carries txRtr (1 = remote request).
- R4: Bits 13 to 18 are the control field: bit 13 is 0, bit 14 is 1, and bits 15 to 18 carry txDlc MSB first.
- R5: The data field follows at bit 19. It holds min(txDlc,8) bytes taken from txData starting at bit 63 downward, and it is empty when txRtr is 1.
- R6: A 16-bit checksum follows the data, MSB first. It is a shift-register CRC with polynomial 0x1021 and a zero seed, computed over every bit from the start bit to the last data bit.
- R7: After the checksum the block sends 9 recessive bits: the acknowledge slot, the acknowledge delimiter and 7 closing bits. The frame length is therefore 44 + 8·bytes bits.
- R8: If the bus is sensed dominant on the tick of the acknowledge slot, done pulses for one clock after the last closing bit, with doneErr at 0 and busy falling in the same cycle.
- R9: If the acknowledge slot stays recessive, retry pulses for one clock after the last closing bit. busy stays 1, and the identical frame is sent again after exactly 3 recessive gap ticks.
- R10: When the 8th attempt in a row goes unacknowledged, done and doneErr pulse together, retry stays 0, and busy falls.
- R11: On a tick within bits 1 to 12 where the block sends 1 but senses 0, lostArb pulses for one clock and busDrive stays 1 for the rest of that frame. The block then retries after the gap time, and this attempt does not count toward the R10 limit.
- R12: busDrive, busy and the pulse outputs change only on the clock edge of a bitTick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-clock strobe marking each bit time |
| startReq | input | 1 | Request to send the frame held on the tx inputs |
| txId | input | 11 | Frame identifier |
| txRtr | input | 1 | 1 = remote request frame (no data) |
| txDlc | input | 4 | Length code in bytes, values above 8 treated as 8 |
| txData | input | 64 | Data bytes, first byte in bits 63:56 |
| busSense | input | 1 | Sensed bus level |
| busDrive | output | 1 | Bus drive level, 0 = pull dominant |
| busy | output | 1 | A frame is pending or being sent |
| done | output | 1 | One-clock pulse when the transfer ends |
| doneErr | output | 1 | With done: retry limit reached |
| lostArb | output | 1 | One-clock pulse on arbitration loss |
| retry | output | 1 | One-clock pulse when a missing acknowledge forces a resend |

## Verification
Two checks can fall on the same tick. One is the arbitration compare on the remote flag, the last bit of the arbitration window. The other is the step that moves the frame into the control field. The test provokes this with a second node that sends the same identifier as a data frame while the block sends a remote request. Only the remote bit differs. The block must flag lostArb on exactly that tick, and it must not drive the reserved bit that follows. A second loss case differs in an early identifier bit. There the block must stay recessive while the other node finishes its arbitration field, and then send a clean frame.

// File: rtl/busFrameTx_pkg.sv
package busFrameTx_pkg;
  localparam int ID_W     = 11;
  localparam int DLC_W    = 4;
  localparam int CRC_W    = 16;
  localparam int SOF_POS  = 0;
  localparam int ID_FIRST = 1;
  localparam int RTR_POS  = ID_W + 1;
  localparam int IDE_POS  = ID_W + 2;
  localparam int RSV_POS  = ID_W + 3;
  localparam int DLC_POS  = ID_W + 4;
  localparam int DATA_POS = DLC_POS + DLC_W;
  localparam int ACK_LEN  = 2;
  localparam int EOF_LEN  = 7;
  localparam int TAIL_LEN = CRC_W + ACK_LEN + EOF_LEN;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_SEND} txState_e;

  typedef struct packed {
    logic load;
    logic crcClear;
    logic crcStep;
    logic crcShift;
  } pathCtl_t;
endpackage

// File: rtl/busFrameTxPath.sv
module busFrameTxPath
  import busFrameTx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter int IDX_W = 7,
  localparam int DATA_W = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [ID_W-1:0]   idIn,
  input  logic              rtrIn,
  input  logic [DLC_W-1:0]  dlcIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic              curBit,
  output logic [IDX_W-1:0]  crcStartIdx,
  output logic [IDX_W-1:0]  ackIdx,
  output logic [IDX_W-1:0]  lastIdx
);
  logic [ID_W-1:0]   idReg;
  logic              rtrReg;
  logic [DLC_W-1:0]  dlcReg;
  logic [DATA_W-1:0] dataReg;
  logic [CRC_W-1:0]  crcReg;

  int nBytes;
  always_comb begin
    if (rtrReg) nBytes = 0;
    else if (int'(dlcReg) > MAX_BYTES) nBytes = MAX_BYTES;
    else nBytes = int'(dlcReg);
    crcStartIdx = IDX_W'(DATA_POS + 8 * nBytes);
    ackIdx      = IDX_W'(DATA_POS + 8 * nBytes + CRC_W);
    lastIdx     = IDX_W'(DATA_POS + 8 * nBytes + TAIL_LEN - 1);
  end

  // bit selector for the frame position held by the control
  logic [ID_W-1:0]   idSh;
  logic [DLC_W-1:0]  dlcSh;
  logic [DATA_W-1:0] dataSh;
  int pos;
  int cStart;
  always_comb begin
    pos    = int'(bitIdx);
    cStart = int'(crcStartIdx);
    idSh   = '0;
    dlcSh  = '0;
    dataSh = '0;
    curBit = 1'b1;
    if (pos == SOF_POS) begin
      curBit = 1'b0;
    end else if (pos < RTR_POS) begin
      idSh   = idReg << (pos - ID_FIRST);
      curBit = idSh[ID_W-1];
    end else if (pos == RTR_POS) begin
      curBit = rtrReg;
    end else if (pos == IDE_POS) begin
      curBit = 1'b0;
    end else if (pos == RSV_POS) begin
      curBit = 1'b1;
    end else if (pos < DATA_POS) begin
      dlcSh  = dlcReg << (pos - DLC_POS);
      curBit = dlcSh[DLC_W-1];
    end else if (pos < cStart) begin
      dataSh = dataReg << (pos - DATA_POS);
      curBit = dataSh[DATA_W-1];
    end else if (pos < cStart + CRC_W) begin
      curBit = crcReg[CRC_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg   <= '0;
      rtrReg  <= 1'b0;
      dlcReg  <= '0;
      dataReg <= '0;
    end else if (ctl.load) begin
      idReg   <= idIn;
      rtrReg  <= rtrIn;
      dlcReg  <= dlcIn;
      dataReg <= dataIn;
    end
  end

  logic feedBack;
  assign feedBack = curBit ^ crcReg[CRC_W-1];

  always_ff @(posedge clk) begin
    if (!rstN || ctl.crcClear) begin
      crcReg <= '0;
    end else if (ctl.crcStep) begin
      crcReg <= {crcReg[CRC_W-2:0], 1'b0} ^ (feedBack ? CRC_POLY : '0);
    end else if (ctl.crcShift) begin
      crcReg <= {crcReg[CRC_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/busFrameTxCtrl.sv
module busFrameTxCtrl
  import busFrameTx_pkg::*;
#(
  parameter int MAX_TRIES = 8,
  parameter int GAP_BITS  = 3,
  parameter int IDX_W     = 7,
  localparam int TRY_W = $clog2(MAX_TRIES + 1),
  localparam int GAP_W = $clog2(GAP_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             startReq,
  input  logic             busSense,
  input  logic             curBit,
  input  logic [IDX_W-1:0] crcStartIdx,
  input  logic [IDX_W-1:0] ackIdx,
  input  logic [IDX_W-1:0] lastIdx,
  output pathCtl_t         ctl,
  output logic [IDX_W-1:0] bitIdx,
  output logic             sending,
  output logic             busy,
  output logic             done,
  output logic             doneErr,
  output logic             lostArb,
  output logic             retry
);
  txState_e          state;
  logic [GAP_W-1:0]  gapCnt;
  logic [TRY_W-1:0]  tries;
  logic              ackSeen;

  assign sending = (state == ST_SEND);
  assign busy    = (state != ST_IDLE);

  logic inArb, arbLoss, gapDone;
  assign inArb   = (bitIdx >= IDX_W'(ID_FIRST)) && (bitIdx <= IDX_W'(RTR_POS));
  assign arbLoss = sending && inArb && curBit && !busSense;
  assign gapDone = busSense && (gapCnt == GAP_W'(GAP_BITS - 1));

  always_comb begin
    ctl = '0;
    if (bitTick) begin
      unique case (state)
        ST_IDLE: ctl.load = startReq;
        ST_GAP:  ctl.crcClear = gapDone;
        ST_SEND: begin
          ctl.crcStep  = !arbLoss && (bitIdx < crcStartIdx);
          ctl.crcShift = !arbLoss && (bitIdx >= crcStartIdx) && (bitIdx < ackIdx);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      gapCnt  <= '0;
      tries   <= '0;
      ackSeen <= 1'b0;
      bitIdx  <= '0;
      done    <= 1'b0;
      doneErr <= 1'b0;
      lostArb <= 1'b0;
      retry   <= 1'b0;
    end else begin
      done    <= 1'b0;
      doneErr <= 1'b0;
      lostArb <= 1'b0;
      retry   <= 1'b0;
      if (bitTick) begin
        unique case (state)
          ST_IDLE: if (startReq) begin
            state  <= ST_GAP;
            gapCnt <= '0;
            tries  <= '0;
          end
          ST_GAP: begin
            if (!busSense) gapCnt <= '0;
            else if (gapDone) begin
              state   <= ST_SEND;
              bitIdx  <= '0;
              ackSeen <= 1'b0;
              gapCnt  <= '0;
            end else gapCnt <= gapCnt + 1'b1;
          end
          ST_SEND: begin
            if (arbLoss) begin
              lostArb <= 1'b1;
              state   <= ST_GAP;
              gapCnt  <= '0;
            end else begin
              if (bitIdx == ackIdx) ackSeen <= !busSense;
              if (bitIdx == lastIdx) begin
                if (ackSeen) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
                end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
                  done    <= 1'b1;
                  doneErr <= 1'b1;
                  state   <= ST_IDLE;
                end else begin
                  tries  <= tries + 1'b1;
                  retry  <= 1'b1;
                  state  <= ST_GAP;
                  gapCnt <= '0;
                end
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/busFrameTx.sv
module busFrameTx
  import busFrameTx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int MAX_TRIES = 8,
  parameter int GAP_BITS  = 3,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  localparam int DATA_W  = MAX_BYTES * 8,
  localparam int MAX_LEN = DATA_POS + DATA_W + TAIL_LEN,
  localparam int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              startReq,
  input  logic [ID_W-1:0]   txId,
  input  logic              txRtr,
  input  logic [DLC_W-1:0]  txDlc,
  input  logic [DATA_W-1:0] txData,
  input  logic              busSense,
  output logic              busDrive,
  output logic              busy,
  output logic              done,
  output logic              doneErr,
  output logic              lostArb,
  output logic              retry
);
  pathCtl_t         ctl;
  logic [IDX_W-1:0] bitIdx, crcStartIdx, ackIdx, lastIdx;
  logic             curBit, sending;

  busFrameTxCtrl #(
    .MAX_TRIES(MAX_TRIES), .GAP_BITS(GAP_BITS), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startReq(startReq),
    .busSense(busSense), .curBit(curBit), .crcStartIdx(crcStartIdx),
    .ackIdx(ackIdx), .lastIdx(lastIdx), .ctl(ctl), .bitIdx(bitIdx),
    .sending(sending), .busy(busy), .done(done), .doneErr(doneErr),
    .lostArb(lostArb), .retry(retry)
  );

  busFrameTxPath #(
    .MAX_BYTES(MAX_BYTES), .CRC_POLY(CRC_POLY), .IDX_W(IDX_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idIn(txId), .rtrIn(txRtr),
    .dlcIn(txDlc), .dataIn(txData), .bitIdx(bitIdx), .curBit(curBit),
    .crcStartIdx(crcStartIdx), .ackIdx(ackIdx), .lastIdx(lastIdx)
  );

  assign busDrive = sending ? curBit : 1'b1;
endmodule

// File: rtl/busFrameTxChk.sv
module busFrameTxChk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic busSense,
  input logic busDrive,
  input logic busy,
  input logic done,
  input logic doneErr,
  input logic lostArb,
  input logic retry
);
  AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> busDrive); // R1

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

  AST_RETRY_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    retry |-> busy); // R9

  AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneErr |-> done); // R10

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, retry, lostArb})); // R10

  AST_LOSS_NEEDS_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    lostArb |-> $past(busDrive && !busSense)); // R11

  AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    lostArb |-> busDrive); // R11

  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitTick) |-> ($stable(busDrive) && $stable(busy))); // R12

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (done || retry || lostArb) |-> $past(bitTick)); // R12
endmodule

bind busFrameTx busFrameTxChk u_chk (.*);

// File: tb/busFrameTx_tb.sv
module busFrameTx_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  int tickCnt = 0;
  logic bitTick;
  always @(posedge clk) tickCnt <= (tickCnt == 3) ? 0 : tickCnt + 1;
  assign bitTick = (tickCnt == 3);

  logic startReq = 1'b0;
  logic [10:0] txId = '0;
  logic txRtr = 1'b0;
  logic [3:0] txDlc = '0;
  logic [63:0] txData = '0;
  logic otherLine = 1'b1;
  logic ackDrive = 1'b1;
  logic busDrive, busy, done, doneErr, lostArb, retry;
  logic busSense;
  assign busSense = busDrive & otherLine & ackDrive;

  busFrameTx u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startReq(startReq),
    .txId(txId), .txRtr(txRtr), .txDlc(txDlc), .txData(txData),
    .busSense(busSense), .busDrive(busDrive), .busy(busy), .done(done),
    .doneErr(doneErr), .lostArb(lostArb), .retry(retry)
  );

  int nChecks = 0;
  int nErrs = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic preEdge();
    do @(negedge clk); while (!bitTick);
  endtask

  task automatic postEdge();
    @(negedge clk);
  endtask

  logic expBits [0:127];

  function automatic int buildExp(input logic [10:0] id, input logic rtr,
                                  input logic [3:0] dlc, input logic [63:0] data,
                                  output int crcStart);
    int n;
    int nb;
    logic [15:0] c;
    logic fb;
    n = 0;
    expBits[n] = 1'b0; n = n + 1;
    for (int i = 10; i >= 0; i--) begin expBits[n] = id[i]; n = n + 1; end
    expBits[n] = rtr; n = n + 1;
    expBits[n] = 1'b0; n = n + 1;
    expBits[n] = 1'b1; n = n + 1;
    for (int i = 3; i >= 0; i--) begin expBits[n] = dlc[i]; n = n + 1; end
    nb = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
    for (int i = 0; i < nb * 8; i++) begin expBits[n] = data[63 - i]; n = n + 1; end
    crcStart = n;
    c = '0;
    for (int i = 0; i < n; i++) begin
      fb = expBits[i] ^ c[15];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    for (int i = 15; i >= 0; i--) begin expBits[n] = c[i]; n = n + 1; end
    for (int i = 0; i < 9; i++) begin expBits[n] = 1'b1; n = n + 1; end
    return n;
  endfunction

  // Waits for a start bit, then records one frame and sorts mismatches by field.
  task automatic captureAttempt(input int len, input int crcStart, input int ackAt,
                                output int gap, output int eSof, output int eArb,
                                output int eCtl, output int eDat, output int eCrc,
                                output int eTail, output int unstable);
    logic lvl;
    gap = 0; eSof = 0; eArb = 0; eCtl = 0; eDat = 0; eCrc = 0; eTail = 0; unstable = 0;
    preEdge();
    while (busSense == 1'b1 && gap < 2000) begin
      gap++;
      postEdge();
      preEdge();
    end
    for (int idx = 0; idx < len; idx++) begin
      if (busSense !== expBits[idx]) begin
        if (idx == 0) eSof++;
        else if (idx <= 12) eArb++;
        else if (idx <= 18) eCtl++;
        else if (idx < crcStart) eDat++;
        else if (idx < crcStart + 16) eCrc++;
        else eTail++;
      end
      if (idx == ackAt) ackDrive = 1'b0;
      postEdge();
      ackDrive = 1'b1;
      lvl = busDrive;
      if (idx < len - 1) begin
        preEdge();
        if (busDrive !== lvl) unstable++;
      end
    end
  endtask

  task automatic fieldChecks(input int eSof, input int eArb, input int eCtl,
                             input int eDat, input int eCrc, input int eTail,
                             input int unstable);
    chk(eSof == 0, "R2", "start bit errors", 64'(eSof), 0);
    chk(eArb == 0, "R3", "arbitration field errors", 64'(eArb), 0);
    chk(eCtl == 0, "R4", "control field errors", 64'(eCtl), 0);
    chk(eDat == 0, "R5", "data field errors", 64'(eDat), 0);
    chk(eCrc == 0, "R6", "checksum errors", 64'(eCrc), 0);
    chk(eTail == 0, "R7", "trailer errors", 64'(eTail), 0);
    chk(unstable == 0, "R12", "drive moved between ticks", 64'(unstable), 0);
  endtask

  task automatic doFrame(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                         input logic [63:0] data, input int ackAttempt);
    int len, cs, gap, eSof, eArb, eCtl, eDat, eCrc, eTail, uns;
    len = buildExp(id, rtr, dlc, data, cs);
    txId = id; txRtr = rtr; txDlc = dlc; txData = data;
    preEdge();
    startReq = 1'b1;
    postEdge();
    startReq = 1'b0;
    chk(busy == 1'b1, "R2", "busy after request", 64'(busy), 1);
    for (int a = 0; a < 8; a++) begin
      captureAttempt(len, cs, (a == ackAttempt) ? len - 9 : -1,
                     gap, eSof, eArb, eCtl, eDat, eCrc, eTail, uns);
      if (a == 0) chk(gap == 3, "R2", "gap before first start bit", 64'(gap), 3);
      else chk(gap == 3, "R9", "gap before resend", 64'(gap), 3);
      fieldChecks(eSof, eArb, eCtl, eDat, eCrc, eTail, uns);
      if (a == ackAttempt) begin
        chk(done && !doneErr && !busy && !retry, "R8", "done/doneErr/busy/retry",
            64'({done, doneErr, busy, retry}), 64'b1000);
        break;
      end else if (a == 7) begin
        chk(done && doneErr && !busy && !retry, "R10", "done/doneErr/busy/retry",
            64'({done, doneErr, busy, retry}), 64'b1100);
      end else begin
        chk(retry && !done && busy, "R9", "done/doneErr/busy/retry",
            64'({done, doneErr, busy, retry}), 64'b0011);
      end
    end
  endtask

  // Another node sends its own arbitration field in step with the block.
  task automatic arbTest(input logic [10:0] dutId, input logic dutRtr,
                         input logic [10:0] othId, input logic othRtr, input int lossIdx);
    logic othBits [0:12];
    int len, cs, gap, eSof, eArb, eCtl, eDat, eCrc, eTail, uns;
    int early, held, guard;
    othBits[0] = 1'b0;
    for (int i = 1; i <= 11; i++) othBits[i] = othId[11 - i];
    othBits[12] = othRtr;
    len = buildExp(dutId, dutRtr, 4'd1, 64'hC300_0000_0000_0000, cs);
    txId = dutId; txRtr = dutRtr; txDlc = 4'd1; txData = 64'hC300_0000_0000_0000;
    preEdge();
    startReq = 1'b1;
    postEdge();
    startReq = 1'b0;
    guard = 0;
    preEdge();
    while (busDrive == 1'b1 && guard < 100) begin
      guard++;
      postEdge();
      preEdge();
    end
    early = 0; held = 0;
    for (int idx = 0; idx <= 12; idx++) begin
      if (idx > 0) preEdge();
      otherLine = othBits[idx];
      if (idx > lossIdx && busDrive !== 1'b1) held++;
      postEdge();
      if (idx < lossIdx && lostArb) early++;
      if (idx == lossIdx)
        chk(lostArb && busDrive, "R11", "lostArb/busDrive at clash bit",
            64'({lostArb, busDrive}), 64'b11);
    end
    otherLine = 1'b1;
    chk(early == 0, "R11", "lostArb before clash bit", 64'(early), 0);
    chk(held == 0, "R11", "drive after loss", 64'(held), 0);
    chk(busy == 1'b1, "R11", "busy after loss", 64'(busy), 1);
    captureAttempt(len, cs, len - 9, gap, eSof, eArb, eCtl, eDat, eCrc, eTail, uns);
    fieldChecks(eSof, eArb, eCtl, eDat, eCrc, eTail, uns);
    chk(done && !doneErr && !busy, "R11", "done after retry", 64'({done, doneErr, busy}), 64'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrs++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    chk(busDrive && !busy && !done && !doneErr && !lostArb && !retry, "R1",
        "reset outputs", 64'({busDrive, busy, done, doneErr, lostArb, retry}), 64'b100000);
    rstN = 1'b1;

    // R2: a request on a clock without a tick is ignored
    preEdge();
    postEdge();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (6) begin preEdge(); postEdge(); end
    chk(!busy && busDrive, "R2", "off-tick request ignored", 64'({busy, busDrive}), 64'b01);

    // Sweep all length codes for data and remote frames (R3..R8)
    for (int r = 0; r < 2; r++) begin
      for (int d = 0; d < 16; d++) begin
        doFrame(11'((d * 37 + r * 500 + 5) & 11'h7FF), 1'(r), 4'(d),
                {8{8'(d * 17 + 1)}} ^ 64'h0123_4567_89AB_CDEF, 0);
      end
    end

    // R9: acknowledged on the third attempt
    doFrame(11'h5A3, 1'b0, 4'd2, 64'hFEDC_BA98_7654_3210, 2);
    // R10: never acknowledged
    doFrame(11'h0F0, 1'b1, 4'd0, 64'h0, 99);

    // R11: clash on an identifier bit, then on the remote bit
    arbTest(11'h1FF, 1'b0, 11'h100, 1'b0, 4);
    arbTest(11'h2A5, 1'b1, 11'h2A5, 1'b0, 12);

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end
endmodule